// File: doc/BRIEF.md
# Capture-Compare General-Purpose Timer

This block is one general-purpose timer unit. It has a free-running 16-bit up-counter fed through an 8-bit prescaler. The prescaler takes its input either from the system clock or from rising edges of an external clock pin. A separate event mode makes the counter advance once per external edge, with the prescaler bypassed. A compare register is checked against the count. A match can clear the counter, drive the output pin as a one-clock pulse or as a toggle, and set a sticky flag. The unit can also latch the running count when a chosen edge arrives on the capture pin.

Software uses a small register port with a write strobe and a combinational read. Through it, software sets the mode, loads or reads the count, reads the captured value and clears the two event flags by writing 1. The interrupt output is the OR of the flags whose interrupt enables are set. Both external pins pass through two-flop synchronizers before edge detection. A capture therefore records the count about three clocks after the pin changes.

Register map (16-bit data, 3-bit address):
- 0 control: bit0 run enable, bit1 external clock source, bit2 event mode, bits4:3 capture edge (00 off, 01 rising, 10 falling, 11 both), bit5 toggle output mode, bit6 clear-on-match, bit7 output enable, bit8 capture interrupt enable, bit9 match interrupt enable.
- 1 prescale: bits7:0, divide by value+1.
- 2 compare value.
- 3 captured value (read only).
- 4 count (read returns the count, write loads it).
- 5 status: bit0 capture flag, bit1 match flag, write 1 to clear.

Any other address reads as zero.

Top module: `capTimer`

## Requirements
- R1: After reset, the count, captured value, control, prescale, compare and status all read 0, and outPin and irq are low.
- R2: With the system clock selected, prescale d, compare r and clear-on-match set, a match occurs every (r+1)*(d+1) clocks.
- R3: While the run enable (control bit0) is 0, the count holds its value and no capture or match event occurs.
- R4: With control bit1 set and event mode off, the counter advances once for every d+1 rising edges of extClkIn.
- R5: With event mode (control bit2) set, the counter advances once per rising edge of extClkIn, and the prescale value has no effect.
- R6: A capture edge chosen by control bits4:3 (01 rising, 10 falling, 11 both) latches the count into the captured register and sets status bit0. An edge of the other polarity is ignored.
- R7: A match occurs on the counter tick taken while the count equals the compare value. With control bit6 set, the counter goes to 0 on that tick. With bit6 clear, it keeps counting and wraps from 0xFFFF to 0.
- R8: In pulse mode (control bit5 = 0) with output enable (bit7) set, each match drives outPin high for exactly one clock. With bit7 clear, outPin stays low.
- R9: In toggle mode (control bit5 = 1) with output enable set, each match inverts outPin.
- R10: Status flags are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: irq is high exactly when (status bit0 and control bit8) or (status bit1 and control bit9).
- R12: Writing address 4 loads the count with the written value and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| extClkIn | input | 1 | External clock / event input (asynchronous) |
| capIn | input | 1 | Capture trigger input (asynchronous) |
| outPin | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that extClkIn and capIn are held for at least two clocks at each level. Under that assumption, every pin transition appears as exactly one synchronized edge, and a capture event corresponds one-to-one with a pin edge. They also assume that software does not shrink the prescale value below the running prescaler count while the timer runs. The stimulus therefore holds each external pin level for four or more clocks. It changes the prescale value only while the run enable is off or right before a count load, which clears the prescaler.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_PS    = 1;
  localparam int ADDR_REF   = 2;
  localparam int ADDR_CAP   = 3;
  localparam int ADDR_COUNT = 4;
  localparam int ADDR_STAT  = 5;

  localparam int CTRL_W     = 10;
  localparam int B_EN       = 0;
  localparam int B_EXTCLK   = 1;
  localparam int B_EVT      = 2;
  localparam int B_CAPLO    = 3;
  localparam int B_CAPHI    = 4;
  localparam int B_TOGGLE   = 5;
  localparam int B_RESTART  = 6;
  localparam int B_OUTEN    = 7;
  localparam int B_CAPIE    = 8;
  localparam int B_REFIE    = 9;

  typedef struct packed {
    logic       en;
    logic       extClk;
    logic       evtMode;
    logic [1:0] capEdge;
    logic       outToggle;
    logic       restart;
    logic       outEn;
  } timerCfg_t;

  typedef struct packed {
    logic loadCnt;   // load count from write data this cycle
    logic holdPs;    // keep prescaler at zero this cycle
  } timerStrobe_t;
endpackage

// File: rtl/capTimerSync.sv
module capTimerSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/capTimerDp.sv
module capTimerDp
  import capTimerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  timerCfg_t        cfg,
  input  timerStrobe_t     strb,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [PS_W-1:0]  psDiv,
  input  logic [CNT_W-1:0] refVal,
  input  logic             extClkIn,
  input  logic             capIn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capReg,
  output logic             outPin,
  output logic             matchEvt,
  output logic             capEvt
);
  logic extSync, extPrev, capSync, capPrev;
  logic extRise, capRise, capFall;
  logic srcTick, psWrap, cntTick;
  logic [PS_W-1:0] psCnt;

  capTimerSync #(.STAGES(SYNC_STAGES)) uExtSync (
    .clk(clk), .rstN(rstN), .d(extClkIn), .q(extSync));
  capTimerSync #(.STAGES(SYNC_STAGES)) uCapSync (
    .clk(clk), .rstN(rstN), .d(capIn), .q(capSync));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      capPrev <= 1'b0;
    end else begin
      extPrev <= extSync;
      capPrev <= capSync;
    end
  end

  assign extRise = extSync & ~extPrev;
  assign capRise = capSync & ~capPrev;
  assign capFall = ~capSync & capPrev;
  assign capEvt  = cfg.en & ((cfg.capEdge[0] & capRise) | (cfg.capEdge[1] & capFall));

  assign srcTick  = cfg.extClk ? extRise : 1'b1;
  assign psWrap   = (psCnt == psDiv);
  assign cntTick  = cfg.en & (cfg.evtMode ? extRise : (srcTick & psWrap));
  assign matchEvt = cntTick & ~strb.loadCnt & (count == refVal);

  always_ff @(posedge clk) begin
    if (!rstN || strb.holdPs)         psCnt <= '0;
    else if (!cfg.evtMode && srcTick) psCnt <= psWrap ? '0 : psCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          count <= '0;
    else if (strb.loadCnt)              count <= loadVal;
    else if (matchEvt && cfg.restart)   count <= '0;
    else if (cntTick)                   count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       capReg <= '0;
    else if (capEvt) capReg <= count;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              outPin <= 1'b0;
    else if (cfg.outToggle) outPin <= outPin ^ (matchEvt & cfg.outEn);
    else                    outPin <= matchEvt & cfg.outEn;
  end

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.en && !strb.loadCnt) |=> $stable(count));
  a_r3_no_event_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |-> (!capEvt && !matchEvt));
  a_r6_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> capReg == $past(count));
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && cfg.restart) |=> count == '0);
  a_r8_pulse_high: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && cfg.outEn && !cfg.outToggle) |=> outPin);
  a_r8_pulse_low: assert property (@(posedge clk) disable iff (!rstN)
    (!matchEvt && !cfg.outToggle) |=> !outPin);
  a_r9_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (matchEvt && cfg.outEn && cfg.outToggle) |=> outPin != $past(outPin));
  a_r12_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> count == $past(loadVal));
endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PS_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  output timerCfg_t         cfg,
  output timerStrobe_t      strb,
  output logic [PS_W-1:0]   psDiv,
  output logic [CNT_W-1:0]  refVal,
  output logic [CNT_W-1:0]  loadVal,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  capReg,
  input  logic              matchEvt,
  input  logic              capEvt,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic capFlag, refFlag;
  logic wrCtrl, wrPs, wrRef, wrCount, wrStat;

  assign wrCtrl  = regWr && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrPs    = regWr && (regAddr == ADDR_W'(ADDR_PS));
  assign wrRef   = regWr && (regAddr == ADDR_W'(ADDR_REF));
  assign wrCount = regWr && (regAddr == ADDR_W'(ADDR_COUNT));
  assign wrStat  = regWr && (regAddr == ADDR_W'(ADDR_STAT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      psDiv   <= '0;
      refVal  <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= regWrData[CTRL_W-1:0];
      if (wrPs)   psDiv   <= regWrData[PS_W-1:0];
      if (wrRef)  refVal  <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFlag <= 1'b0;
      refFlag <= 1'b0;
    end else begin
      capFlag <= capEvt   | (capFlag & ~(wrStat & regWrData[0]));
      refFlag <= matchEvt | (refFlag & ~(wrStat & regWrData[1]));
    end
  end

  always_comb begin
    cfg.en        = ctrlReg[B_EN];
    cfg.extClk    = ctrlReg[B_EXTCLK];
    cfg.evtMode   = ctrlReg[B_EVT];
    cfg.capEdge   = ctrlReg[B_CAPHI:B_CAPLO];
    cfg.outToggle = ctrlReg[B_TOGGLE];
    cfg.restart   = ctrlReg[B_RESTART];
    cfg.outEn     = ctrlReg[B_OUTEN];
    strb.loadCnt  = wrCount;
    strb.holdPs   = wrCount | ~ctrlReg[B_EN];
  end

  assign loadVal = regWrData;
  assign irq = (capFlag & ctrlReg[B_CAPIE]) | (refFlag & ctrlReg[B_REFIE]);

  always_comb begin
    unique case (regAddr)
      ADDR_W'(ADDR_CTRL):  regRdData = {{(CNT_W-CTRL_W){1'b0}}, ctrlReg};
      ADDR_W'(ADDR_PS):    regRdData = {{(CNT_W-PS_W){1'b0}}, psDiv};
      ADDR_W'(ADDR_REF):   regRdData = refVal;
      ADDR_W'(ADDR_CAP):   regRdData = capReg;
      ADDR_W'(ADDR_COUNT): regRdData = count;
      ADDR_W'(ADDR_STAT):  regRdData = {{(CNT_W-2){1'b0}}, refFlag, capFlag};
      default:             regRdData = '0;
    endcase
  end

  a_r10_match_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |=> refFlag);
  a_r10_cap_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    capEvt |=> capFlag);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && !wrStat) |=> refFlag);
  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (capFlag || refFlag));
endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              extClkIn,
  input  logic              capIn,
  output logic              outPin,
  output logic              irq
);
  timerCfg_t        cfg;
  timerStrobe_t     strb;
  logic [PS_W-1:0]  psDiv;
  logic [CNT_W-1:0] refVal, loadVal, count, capReg;
  logic             matchEvt, capEvt;

  capTimerCtrl #(.CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .cfg(cfg), .strb(strb),
    .psDiv(psDiv), .refVal(refVal), .loadVal(loadVal), .count(count),
    .capReg(capReg), .matchEvt(matchEvt), .capEvt(capEvt), .irq(irq));

  capTimerDp #(.CNT_W(CNT_W), .PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb), .loadVal(loadVal),
    .psDiv(psDiv), .refVal(refVal), .extClkIn(extClkIn), .capIn(capIn),
    .count(count), .capReg(capReg), .outPin(outPin), .matchEvt(matchEvt),
    .capEvt(capEvt));
endmodule

// File: tb/tb_capTimer.sv
module tb_capTimer;
  localparam int A_CTRL = 0, A_PS = 1, A_REF = 2, A_CAP = 3, A_CNT = 4, A_STAT = 5;
  localparam int EN = 1, EXTCLK = 2, EVT = 4, CRISE = 8, CFALL = 16, CBOTH = 24;
  localparam int TOG = 32, RST = 64, OUTEN = 128, CAPIE = 256, REFIE = 512;

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWr = 1'b0;
  logic [15:0] regWrData = '0, regRdData;
  logic extClkIn = 1'b0, capIn = 1'b0;
  logic outPin, irq;

  int total = 0, bad = 0;
  bit done = 0;
  int expQ[$];
  bit monOn = 0, monPulse = 0;

  always #10 clk = ~clk;

  capTimer dut (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .extClkIn(extClkIn),
    .capIn(capIn), .outPin(outPin), .irq(irq));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(int a, int d);
    @(negedge clk);
    regAddr = 3'(a); regWrData = 16'(d); regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(int a, output int v);
    @(negedge clk);
    regAddr = 3'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseExt(int n);
    for (int i = 0; i < n; i++) begin
      extClkIn = 1'b1; waitCyc(4);
      extClkIn = 1'b0; waitCyc(4);
    end
  endtask

  // driver side of the scoreboard: expected gap between rising edges of outPin
  task automatic pushGaps(int gap, int n);
    for (int i = 0; i < n; i++) expQ.push_back(gap);
  endtask

  // monitor: measures outPin rising-edge spacing and pulse width
  initial begin
    int cyc = 0, lastRise = 0;
    bit armed = 0;
    logic prevOut = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (monOn) begin
        if (outPin && !prevOut) begin
          if (armed && expQ.size() > 0) check("R2 match spacing", cyc - lastRise, expQ.pop_front());
          armed = 1;
          lastRise = cyc;
        end
        if (monPulse && prevOut) check("R8 pulse one clock", int'(outPin), 0);
      end else armed = 0;
      prevOut = outPin;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, c0;
    waitCyc(3);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      readReg(a, v); check("R1 reset register", v, 0);
    end
    check("R1 reset outPin", int'(outPin), 0);
    check("R1 reset irq", int'(irq), 0);

    // R12 load while stopped
    writeReg(A_CNT, 16'h55AA);
    readReg(A_CNT, v); check("R12 count load", v, 16'h55AA);

    // R2 / R8 pulse spacing, prescale 0
    writeReg(A_REF, 4);
    writeReg(A_CTRL, RST | OUTEN);
    writeReg(A_CNT, 0);
    monOn = 1; monPulse = 1;
    pushGaps(5, 3);
    writeReg(A_CTRL, EN | RST | OUTEN);
    waitCyc(40);
    check("R2 scoreboard drained d=0", expQ.size(), 0);
    // R7 restart keeps count within compare
    for (int i = 0; i < 4; i++) begin
      readReg(A_CNT, v);
      check("R7 restart bound", int'(v <= 4), 1);
      waitCyc(1);
    end
    monOn = 0;

    // R2 prescale 2
    writeReg(A_CTRL, RST | OUTEN);
    writeReg(A_PS, 2);
    writeReg(A_CNT, 0);
    monOn = 1;
    pushGaps(15, 3);
    writeReg(A_CTRL, EN | RST | OUTEN);
    waitCyc(80);
    check("R2 scoreboard drained d=2", expQ.size(), 0);
    monOn = 0; monPulse = 0;

    // R9 toggle: rising edges every two matches
    writeReg(A_CTRL, RST | OUTEN | TOG);
    writeReg(A_PS, 0);
    writeReg(A_REF, 2);
    writeReg(A_CNT, 0);
    monOn = 1;
    pushGaps(6, 3);
    writeReg(A_CTRL, EN | RST | OUTEN | TOG);
    waitCyc(40);
    check("R9 toggle scoreboard drained", expQ.size(), 0);
    monOn = 0;

    // R8 output disabled: pin stays low, match flag still set
    writeReg(A_CTRL, RST);
    writeReg(A_STAT, 3);
    writeReg(A_CNT, 0);
    writeReg(A_CTRL, EN | RST);
    v = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (outPin) v = 1;
    end
    check("R8 outPin low when output disabled", v, 0);
    readReg(A_STAT, v); check("R8 match flag while output disabled", v & 2, 2);

    // R10 write 0 keeps flag; R11 irq from match flag
    writeReg(A_CTRL, 0);
    writeReg(A_STAT, 0);
    readReg(A_STAT, v); check("R10 write 0 no effect", v & 2, 2);
    writeReg(A_CTRL, REFIE);
    check("R11 irq from match flag", int'(irq), 1);
    writeReg(A_STAT, 2);
    readReg(A_STAT, v); check("R10 write 1 clears", v, 0);
    check("R11 irq low after clear", int'(irq), 0);

    // R7 wrap without restart
    writeReg(A_CTRL, 0);
    writeReg(A_REF, 3);
    writeReg(A_CNT, 16'hFFF0);
    writeReg(A_CTRL, EN);
    waitCyc(30);
    writeReg(A_CTRL, 0);
    readReg(A_CNT, v);
    check("R7 wrapped past compare", int'(v > 3 && v < 16'h40), 1);
    readReg(A_STAT, v); check("R7 match after wrap", v & 2, 2);
    writeReg(A_STAT, 3);

    // R3 stopped: count holds, capture ignored
    readReg(A_CNT, c0);
    writeReg(A_CTRL, CBOTH);
    capIn = 1'b1; waitCyc(10); capIn = 1'b0; waitCyc(10);
    waitCyc(30);
    readReg(A_CNT, v); check("R3 count holds when stopped", v, c0);
    readReg(A_STAT, v); check("R3 no capture when stopped", v, 0);
    readReg(A_CAP, v); check("R3 capture register unchanged", v, 0);

    // R6 capture edges, prescale 255 keeps count steady
    writeReg(A_PS, 255);
    writeReg(A_CTRL, EN | CRISE);
    writeReg(A_CNT, 16'h1234);
    capIn = 1'b1; waitCyc(10);
    readReg(A_CAP, v); check("R6 rising capture value", v, 16'h1234);
    readReg(A_STAT, v); check("R6 rising capture flag", v, 1);
    writeReg(A_CTRL, EN | CRISE | CAPIE);
    check("R11 irq from capture flag", int'(irq), 1);
    writeReg(A_CTRL, EN | CRISE);
    check("R11 irq masked", int'(irq), 0);
    writeReg(A_STAT, 1);
    capIn = 1'b0; waitCyc(10);
    readReg(A_STAT, v); check("R6 falling ignored in rising mode", v, 0);

    writeReg(A_CTRL, EN | CFALL);
    writeReg(A_CNT, 16'h2222);
    capIn = 1'b1; waitCyc(10);
    readReg(A_STAT, v); check("R6 rising ignored in falling mode", v, 0);
    capIn = 1'b0; waitCyc(10);
    readReg(A_CAP, v); check("R6 falling capture value", v, 16'h2222);
    readReg(A_STAT, v); check("R6 falling capture flag", v, 1);
    writeReg(A_STAT, 1);

    writeReg(A_CTRL, EN | CBOTH);
    writeReg(A_CNT, 16'h3333);
    capIn = 1'b1; waitCyc(10);
    readReg(A_CAP, v); check("R6 both mode rising", v, 16'h3333);
    writeReg(A_CNT, 16'h4444);
    capIn = 1'b0; waitCyc(10);
    readReg(A_CAP, v); check("R6 both mode falling", v, 16'h4444);
    writeReg(A_STAT, 1);

    // R4 external clock source, divide by 2
    writeReg(A_CTRL, 0);
    writeReg(A_PS, 1);
    writeReg(A_REF, 16'hFFFF);
    writeReg(A_CNT, 0);
    writeReg(A_CTRL, EN | EXTCLK);
    waitCyc(20);
    readReg(A_CNT, v); check("R4 no advance without external edges", v, 0);
    pulseExt(10);
    readReg(A_CNT, v); check("R4 external clock divided", v, 5);

    // R5 event mode, prescale ignored
    writeReg(A_CTRL, 0);
    writeReg(A_PS, 7);
    writeReg(A_CNT, 0);
    writeReg(A_CTRL, EN | EVT);
    pulseExt(7);
    readReg(A_CNT, v); check("R5 event count", v, 7);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule